// File: doc/BRIEF.md
# Processor status trace encoder

The encoder watches per-cycle execution events from a simple processor core and turns them into two registered output streams for an external trace probe. The first is a 5-bit status code on every clock. The second is a 4-bit data stream that carries captured operand bytes and branch-target addresses, one nibble per clock. Back-to-back single-cycle ordinary instructions are collapsed into one count code. Each byte payload is preceded by a marker code that tells the probe how many bytes follow.

The core presents an instruction-start strobe with a class, or a user-mode-entry flag, together with the operand, the operand size and the branch target. Three configuration bits decide whether operand bytes are captured, whether branch targets are captured, and whether targets use two or three bytes. When the encoder cannot take a request in the current cycle it raises `busy`. The core must hold the request, unchanged, until `busy` is low. This happens when a pending count must go out first, when a marker owns the status slot, or when the data stream is still occupied.

Top module: `pst_trace_enc`

## Requirements
- R1: After reset, `pst` is 0x00, `ddata` is 0x0 and `busy` is low.
- R2: An ordinary instruction is sequential when it is a single-cycle instruction (`ev_cls`=0, `ev_multi`=0) and its operand is not captured. Each accepted sequential instruction puts 0x00 on `pst` at the next clock edge and adds one to a pending count. In the first cycle that has no sequential instruction, the count is sent out as 0x01 if it is 1, or as 0x10+N if it is N (2 to 9), and the count then clears.
- R3: When the tenth sequential instruction of a run is accepted, `pst` shows 0x1A at the next edge and the count restarts from zero.
- R4: A non-sequential request that arrives while a count is pending raises `busy` for exactly one cycle. In that cycle the count code goes out. The held request takes effect in the cycle after.
- R5: A multi-cycle ordinary instruction (`ev_multi`=1) shows 0x01. The following cycles with no request show 0x00.
- R6: The class encoding of `ev_cls` is 1 = taken branch, 2 = exception return, 3 = pulse marker, 4 = write-data. These classes show 0x05, 0x07, 0x04 and 0x04. A `um_enter` flag with no strobe shows 0x03.
- R7: A write-data instruction is always followed by a payload. `ev_size` 0, 1 and 2 give markers 0x08, 0x09 and 0x0B and payloads of 1, 2 and 4 bytes. The marker appears on `pst` one cycle after the instruction code, in the same cycle as the first nibble. Nibbles go least-significant first, one per clock. `ddata` is 0x0 when no payload is being sent.
- R8: A taken branch with `cfg_bcap`=1 is followed by a marker and a payload. With `cfg_addr3`=0 the marker is 0x0D and the payload is target bits 16:1. With `cfg_addr3`=1 the marker is 0x0E and the payload is target bits 23:1. With `cfg_bcap`=0 no marker follows and `ddata` stays 0x0.
- R9: An ordinary instruction with `ev_dacc`=1 and `cfg_dcap`=1 shows 0x01, followed by the size marker and operand payload of R7. With `cfg_dcap`=0 the same instruction is sequential and nothing goes out on `ddata`.
- R10: `busy` is raised for any request while a marker is pending, and for a payload request while more than one nibble of the previous payload is still to be sent. A request is accepted in the cycle in which the last previous nibble leaves, so the data stream stays gap-free.
- R11: The codes 0x02, 0x06, 0x0A, 0x0C, 0x0F, 0x10, 0x11 and anything above 0x1A never appear on `pst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Instruction-start strobe |
| ev_cls | input | 3 | Instruction class (0 ordinary, 1 branch, 2 exception return, 3 pulse, 4 write-data) |
| ev_multi | input | 1 | Instruction takes more than one clock |
| ev_dacc | input | 1 | Ordinary instruction carries a data-access operand |
| ev_size | input | 2 | Operand size: 0 byte, 1 halfword, 2 word |
| ev_opnd | input | OPND_W | Operand value |
| ev_target | input | ADDR_W | Branch target address |
| um_enter | input | 1 | Previous instruction entered user mode |
| cfg_dcap | input | 1 | Enable operand capture |
| cfg_bcap | input | 1 | Enable branch-target capture |
| cfg_addr3 | input | 1 | Branch target uses three bytes instead of two |
| pst | output | 5 | Registered status code |
| ddata | output | 4 | Registered data nibble |
| busy | output | 1 | Request not taken this cycle; hold it |

## Verification
The hardest case to reach from the ports is two payloads back to back. The second request must wait through the marker slot and then through all but the last nibble of the first payload. It must then be taken exactly as the final nibble leaves. The bench starts a four-byte write-data payload and at once presents a one-byte write-data request. It holds that request while counting the `busy` cycles, and expects seven of them. It then checks that the new instruction code and marker follow with no gap on the data stream. It also tests a run that crosses the ten-instruction limit and runs that are cut short by an exception return and by a user-mode flag.

// File: rtl/pst_pkg.sv
// Package pst_pkg
// Shared class encoding and status code values for the trace encoder.
// Assumes a 5-bit status code; the count codes start at RUN_BASE.
package pst_pkg;
    typedef enum logic [2:0] {
        CLS_ORD    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_RTE    = 3'd2,
        CLS_PULSE  = 3'd3,
        CLS_WDATA  = 3'd4
    } ev_cls_e;

    localparam logic [4:0] PST_CONT     = 5'h00;
    localparam logic [4:0] PST_INSN     = 5'h01;
    localparam logic [4:0] PST_UMODE    = 5'h03;
    localparam logic [4:0] PST_MARK     = 5'h04;
    localparam logic [4:0] PST_BRANCH   = 5'h05;
    localparam logic [4:0] PST_RTE      = 5'h07;
    localparam logic [4:0] PST_D1       = 5'h08;
    localparam logic [4:0] PST_D2       = 5'h09;
    localparam logic [4:0] PST_D4       = 5'h0B;
    localparam logic [4:0] PST_A2       = 5'h0D;
    localparam logic [4:0] PST_A3       = 5'h0E;
    localparam logic [4:0] PST_RUN_BASE = 5'h10;
    localparam logic [4:0] PST_RUN_TOP  = 5'h1A;

    // Codes that the probe must never see
    function automatic logic pst_is_reserved(input logic [4:0] c);
        return (c == 5'h02) || (c == 5'h06) || (c == 5'h0A) || (c == 5'h0C) ||
               (c == 5'h0F) || (c == 5'h10) || (c == 5'h11) || (c > PST_RUN_TOP);
    endfunction
endpackage

// File: rtl/pst_run_ctr.sv
// Module pst_run_ctr
// Counts accepted sequential instructions of the current run.
// Raises wrap when the run reaches RUN_MAX, and clears on wrap or on flush.
// Assumes seq_acc and flush are never high together.
module pst_run_ctr #(
    parameter int RUN_MAX = 10,
    localparam int CW = $clog2(RUN_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_acc,
    input  logic          flush,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    // Last instruction of a full run
    always_comb wrap = seq_acc && (cnt == CW'(RUN_MAX - 1));

    // Run length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (flush || wrap) begin
            cnt <= '0;
        end else if (seq_acc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pst_nib_shifter.sv
// Module pst_nib_shifter
// Holds one payload and sends it out least-significant nibble first, one per clock.
// On load it sets mark_pend, so the caller can place the marker code beside the first nibble.
// Assumes load comes only when at most one nibble is still left.
module pst_nib_shifter #(
    parameter int PAY_W = 32,
    parameter int NIB_W = 4,
    localparam int NIBS = PAY_W / NIB_W,
    localparam int RW   = $clog2(NIBS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAY_W-1:0] load_data,
    input  logic [RW-1:0]    load_nibs,
    input  logic [4:0]       load_mark,
    output logic             mark_pend,
    output logic [4:0]       mark_code,
    output logic [RW-1:0]    rem,
    output logic [NIB_W-1:0] ddata
);
    logic [PAY_W-1:0] sh;

    // Shift out the current payload and take a new one when it is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            rem       <= '0;
            ddata     <= '0;
            mark_pend <= 1'b0;
            mark_code <= '0;
        end else begin
            if (rem != '0) begin
                ddata <= sh[NIB_W-1:0];
                sh    <= sh >> NIB_W;
                rem   <= rem - 1'b1;
            end else begin
                ddata <= '0;
            end
            mark_pend <= load;
            if (load) begin
                sh        <= load_data;
                rem       <= load_nibs;
                mark_code <= load_mark;
            end
        end
    end
endmodule

// File: rtl/pst_trace_enc.sv
// Module pst_trace_enc
// Turns core execution events into a registered status code stream and a nibble data stream.
// Sequential single-cycle instructions are compressed into count codes.
// Payload events emit a marker that matches their size.
// Assumes the core holds its request unchanged while busy is high.
// Assumes ev_valid and um_enter are never high together, and ADDR_W >= 24.
module pst_trace_enc
    import pst_pkg::*;
#(
    parameter int OPND_W  = 32,
    parameter int ADDR_W  = 24,
    parameter int RUN_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [2:0]        ev_cls,
    input  logic              ev_multi,
    input  logic              ev_dacc,
    input  logic [1:0]        ev_size,
    input  logic [OPND_W-1:0] ev_opnd,
    input  logic [ADDR_W-1:0] ev_target,
    input  logic              um_enter,
    input  logic              cfg_dcap,
    input  logic              cfg_bcap,
    input  logic              cfg_addr3,
    output logic [4:0]        pst,
    output logic [3:0]        ddata,
    output logic              busy
);
    localparam int NIB_W = 4;
    localparam int PAY_W = OPND_W;
    localparam int RW    = $clog2(PAY_W / NIB_W + 1);
    localparam int CW    = $clog2(RUN_MAX + 1);

    logic          is_ord, is_br, is_wd, dcap_hit;
    logic          req, seq, pay_req, flush, accept, seq_acc, load;
    logic [CW-1:0] run_cnt;
    logic          wrap;
    logic          mark_pend;
    logic [4:0]    mark_code;
    logic [RW-1:0] rem;
    logic [PAY_W-1:0] pay_data;
    logic [RW-1:0]    pay_nibs;
    logic [4:0]       pay_mark;
    logic [4:0]       ev_code, run_code, pst_nxt;

    // Classify the current request
    always_comb begin
        is_ord   = (ev_cls == CLS_ORD);
        is_br    = (ev_cls == CLS_BRANCH);
        is_wd    = (ev_cls == CLS_WDATA);
        dcap_hit = is_ord && ev_dacc && cfg_dcap;
        req      = ev_valid || um_enter;
        seq      = ev_valid && is_ord && !ev_multi && !dcap_hit;
        pay_req  = ev_valid && (is_wd || dcap_hit || (is_br && cfg_bcap));
    end

    // Decide whether the request is taken or stalled
    always_comb begin
        flush   = !mark_pend && (run_cnt != '0) && !seq;
        busy    = req && (mark_pend || flush || (pay_req && (rem > RW'(1))));
        accept  = req && !busy;
        seq_acc = accept && seq;
        load    = accept && pay_req;
    end

    // Payload contents, nibble count and marker for the accepted request
    always_comb begin
        if (is_br) begin
            pay_data = PAY_W'(ev_target >> 1);
            pay_nibs = cfg_addr3 ? RW'(6) : RW'(4);
            pay_mark = cfg_addr3 ? PST_A3 : PST_A2;
        end else begin
            pay_data = ev_opnd;
            case (ev_size)
                2'd0:    begin pay_nibs = RW'(2); pay_mark = PST_D1; end
                2'd1:    begin pay_nibs = RW'(4); pay_mark = PST_D2; end
                default: begin pay_nibs = RW'(8); pay_mark = PST_D4; end
            endcase
        end
    end

    // Status code of the accepted request itself
    always_comb begin
        if (!ev_valid) begin
            ev_code = PST_UMODE;
        end else begin
            case (ev_cls)
                CLS_BRANCH: ev_code = PST_BRANCH;
                CLS_RTE:    ev_code = PST_RTE;
                CLS_PULSE:  ev_code = PST_MARK;
                CLS_WDATA:  ev_code = PST_MARK;
                default:    ev_code = PST_INSN;
            endcase
        end
    end

    // Pick the code for the next status slot
    always_comb begin
        run_code = (run_cnt == CW'(1)) ? PST_INSN : (PST_RUN_BASE + 5'(run_cnt));
        if (mark_pend)    pst_nxt = mark_code;
        else if (flush)   pst_nxt = run_code;
        else if (seq_acc) pst_nxt = wrap ? (PST_RUN_BASE + 5'(RUN_MAX)) : PST_CONT;
        else if (accept)  pst_nxt = ev_code;
        else              pst_nxt = PST_CONT;
    end

    // Status output register
    always_ff @(posedge clk) begin
        if (!rst_n) pst <= PST_CONT;
        else        pst <= pst_nxt;
    end

    pst_run_ctr #(.RUN_MAX(RUN_MAX)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .seq_acc (seq_acc),
        .flush   (flush),
        .cnt     (run_cnt),
        .wrap    (wrap)
    );

    pst_nib_shifter #(.PAY_W(PAY_W), .NIB_W(NIB_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (pay_data),
        .load_nibs (pay_nibs),
        .load_mark (pay_mark),
        .mark_pend (mark_pend),
        .mark_code (mark_code),
        .rem       (rem),
        .ddata     (ddata)
    );
endmodule

// File: rtl/pst_trace_enc_chk.sv
// Module pst_trace_enc_chk
// Temporal checks on the trace encoder, bound to every instance of it.
// Assumes the core keeps the capture configuration stable around a payload.
module pst_trace_enc_chk
    import pst_pkg::*;
#(
    parameter int RUN_MAX = 10,
    localparam int CW = $clog2(RUN_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_valid,
    input logic [2:0]    ev_cls,
    input logic          um_enter,
    input logic          cfg_bcap,
    input logic          cfg_addr3,
    input logic [4:0]    pst,
    input logic          busy,
    input logic [CW-1:0] run_cnt
);
    // R11
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pst_is_reserved(pst));

    // R10
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ev_valid || um_enter));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(RUN_MAX));

    // R4
    flush_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && busy && (run_cnt != '0)) |=>
        ((pst == PST_INSN) || ((pst >= 5'h12) && (pst <= PST_RUN_TOP))));

    // R7
    wdata_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !busy && (ev_cls == CLS_WDATA)) |=>
        (pst == PST_MARK) ##1 ((pst == PST_D1) || (pst == PST_D2) || (pst == PST_D4)));

    // R8
    branch_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !busy && (ev_cls == CLS_BRANCH) && cfg_bcap && cfg_addr3) |=>
        (pst == PST_BRANCH) ##1 (pst == PST_A3));
endmodule

bind pst_trace_enc pst_trace_enc_chk #(.RUN_MAX(RUN_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_cls    (ev_cls),
    .um_enter  (um_enter),
    .cfg_bcap  (cfg_bcap),
    .cfg_addr3 (cfg_addr3),
    .pst       (pst),
    .busy      (busy),
    .run_cnt   (run_cnt)
);

// File: tb/pst_trace_enc_bench.sv
`timescale 1ns/1ps
// Bench pst_trace_enc_bench
// Directed scenarios. Each task drives its pattern and checks the status and data streams.
// Inputs change 1 ns after a rising edge; outputs are read in that same window.
module pst_trace_enc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_cls = 3'd0;
    logic        ev_multi = 1'b0;
    logic        ev_dacc = 1'b0;
    logic [1:0]  ev_size = 2'd0;
    logic [31:0] ev_opnd = '0;
    logic [23:0] ev_target = '0;
    logic        um_enter = 1'b0;
    logic        cfg_dcap = 1'b0;
    logic        cfg_bcap = 1'b0;
    logic        cfg_addr3 = 1'b0;
    logic [4:0]  pst;
    logic [3:0]  ddata;
    logic        busy;

    int n_run = 0;
    int n_fail = 0;
    int resv_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pst_trace_enc u_pst_trace_enc (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_cls(ev_cls),
        .ev_multi(ev_multi), .ev_dacc(ev_dacc), .ev_size(ev_size), .ev_opnd(ev_opnd),
        .ev_target(ev_target), .um_enter(um_enter), .cfg_dcap(cfg_dcap),
        .cfg_bcap(cfg_bcap), .cfg_addr3(cfg_addr3), .pst(pst), .ddata(ddata), .busy(busy)
    );

    // Count forbidden status codes seen at any time after reset
    always @(negedge clk) begin
        if (rst_n && ((pst == 5'h02) || (pst == 5'h06) || (pst == 5'h0A) || (pst == 5'h0C) ||
                      (pst == 5'h0F) || (pst == 5'h10) || (pst == 5'h11) || (pst > 5'h1A)))
            resv_seen++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [2:0] c, input logic multi, input logic dacc,
                       input logic [1:0] sz, input logic [31:0] op, input logic [23:0] tg);
        ev_valid = 1'b1; ev_cls = c; ev_multi = multi; ev_dacc = dacc;
        ev_size = sz; ev_opnd = op; ev_target = tg;
    endtask

    task automatic drop();
        ev_valid = 1'b0; um_enter = 1'b0; ev_multi = 1'b0; ev_dacc = 1'b0;
    endtask

    // Read the payload that starts in this cycle, next to its marker
    task automatic collect(input int nibs, input int mark, input string tag, input int exp);
        int v;
        tick();
        chk({tag, " marker"}, pst, mark);
        v = ddata;
        for (int i = 1; i < nibs; i++) begin
            tick();
            v = v | (int'(ddata) << (4 * i));
        end
        chk({tag, " payload"}, v, exp);
        tick();
        chk({tag, " data idle after"}, ddata, 0);
    endtask

    task automatic t_reset();
        chk("R1 pst after reset", pst, 0);
        chk("R1 ddata after reset", ddata, 0);
        chk("R1 busy after reset", busy, 0);
    endtask

    task automatic t_single();
        put(3'd0, 0, 0, 0, 0, 0); tick(); chk("R2 single accum", pst, 8'h00);
        drop(); tick(); chk("R2 run of one", pst, 8'h01);
        tick(); chk("R2 idle after flush", pst, 8'h00);
    endtask

    task automatic t_run5();
        put(3'd0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin tick(); chk("R2 run5 accum", pst, 0); end
        drop(); tick(); chk("R2 run of five", pst, 8'h15);
    endtask

    task automatic t_run12();
        put(3'd0, 0, 0, 0, 0, 0);
        for (int i = 1; i <= 12; i++) begin
            tick(); chk("R3 run12 step", pst, (i == 10) ? 8'h1A : 8'h00);
        end
        drop(); tick(); chk("R3 remainder after wrap", pst, 8'h12);
    endtask

    task automatic t_rte_flush();
        put(3'd0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick();
        put(3'd2, 0, 0, 0, 0, 0); #1;
        chk("R4 busy on flush", busy, 1);
        tick(); chk("R4 flush code", pst, 8'h13);
        #1; chk("R4 busy released", busy, 0);
        tick(); chk("R6 exception return code", pst, 8'h07);
        drop(); tick(); chk("R4 idle", pst, 0);
    endtask

    task automatic t_multi();
        put(3'd0, 1, 0, 0, 0, 0); tick(); chk("R5 multi first", pst, 8'h01);
        drop(); tick(); chk("R5 multi extra", pst, 0);
        tick(); chk("R5 multi extra 2", pst, 0);
    endtask

    task automatic t_pulse_um();
        put(3'd3, 0, 0, 0, 0, 0); tick(); chk("R6 pulse code", pst, 8'h04);
        drop(); tick(); chk("R6 pulse no marker", pst, 0);
        chk("R6 pulse no data", ddata, 0);
        put(3'd0, 0, 0, 0, 0, 0); tick(); tick();
        drop(); um_enter = 1'b1; #1;
        chk("R4 busy on user-mode flag", busy, 1);
        tick(); chk("R4 flush before user mode", pst, 8'h12);
        tick(); chk("R6 user-mode code", pst, 8'h03);
        drop(); tick();
    endtask

    task automatic t_wdata();
        put(3'd4, 0, 0, 1, 32'h0000A5C3, 0); tick(); chk("R7 wdata code", pst, 8'h04);
        drop(); collect(4, 8'h09, "R7 wdata 2B", 32'hA5C3);
        put(3'd4, 0, 0, 0, 32'h0000005A, 0); tick();
        drop(); collect(2, 8'h08, "R7 wdata 1B", 32'h5A);
    endtask

    task automatic t_branch();
        cfg_bcap = 1'b1; cfg_addr3 = 1'b1;
        put(3'd1, 0, 0, 0, 0, 24'h123456); tick(); chk("R8 branch code", pst, 8'h05);
        drop(); collect(6, 8'h0E, "R8 branch 3B", 32'h091A2B);
        cfg_addr3 = 1'b0;
        put(3'd1, 0, 0, 0, 0, 24'h01ABCD); tick();
        drop(); collect(4, 8'h0D, "R8 branch 2B", 32'hD5E6);
        cfg_bcap = 1'b0;
        put(3'd1, 0, 0, 0, 0, 24'h123456); tick(); chk("R8 branch no capture", pst, 8'h05);
        drop(); tick(); chk("R8 no marker", pst, 0);
        chk("R8 no data", ddata, 0);
    endtask

    task automatic t_dcap();
        cfg_dcap = 1'b1;
        put(3'd0, 0, 1, 0, 32'h0000007E, 0); tick(); chk("R9 capture code", pst, 8'h01);
        drop(); collect(2, 8'h08, "R9 capture 1B", 32'h7E);
        cfg_dcap = 1'b0;
        put(3'd0, 0, 1, 0, 32'h0000007E, 0); tick(); chk("R9 no capture is sequential", pst, 0);
        drop(); tick(); chk("R9 flushed as one", pst, 8'h01);
        chk("R9 no data", ddata, 0);
    endtask

    task automatic t_stall();
        int stalls;
        put(3'd4, 0, 0, 2, 32'h87654321, 0); tick(); chk("R7 4B code", pst, 8'h04);
        put(3'd4, 0, 0, 0, 32'h0000009C, 0); #1;
        chk("R10 busy in marker slot", busy, 1);
        tick(); chk("R10 4B marker", pst, 8'h0B); chk("R10 first nibble", ddata, 1);
        stalls = 1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (!busy) break;
            stalls++;
            tick();
        end
        chk("R10 stall cycles", stalls, 7);
        tick(); chk("R10 accepted code", pst, 8'h04); chk("R10 last old nibble", ddata, 8);
        drop(); tick(); chk("R10 new marker", pst, 8'h08); chk("R10 new nibble", ddata, 8'hC);
        tick(); chk("R10 new nibble 2", ddata, 9);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            chk("R11 reserved codes seen", resv_seen, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_single();
        t_run5();
        t_run12();
        t_rte_flush();
        t_multi();
        t_pulse_um();
        t_wdata();
        t_branch();
        t_dcap();
        t_stall();
        finish_run();
    end
endmodule